// File: doc/BRIEF.md
# Drawing Engine Interrupt Status and Control Register

This block is the event-flag register of a 2D drawing engine. Ten internal sources feed it: vertical sync, engine busy, bus-interface FIFO full and empty, command FIFO full and empty, a burst-command event, a port event, and the command buffer's high and low threshold crossings. Each source is a level input. A rising edge on a source latches that event's status bit, whether or not the event is enabled. The block drives a single interrupt line, which is the OR over all events of latched status AND enable.

One bus address serves two registers. A read at that address returns the latched status word. A write at that address loads a control word with three parts: per-event clear bits, which sit at the same positions as the status bits; per-event enable bits; and a drawing-engine soft-reset bit. Software sets the reset bit, waits, and then writes it back to zero. While the reset bit is held, the engine-reset output is high and every latched event is dropped.

Top module: `gfx_irq_regs`

## Requirements
- R1: After the synchronous active-low reset, status reads as zero, `irq` is low and `engine_reset` is low.
- R2: A rising edge on `ev_src[e]` sets status bit e on the next clock edge, whether or not event e is enabled. A source held high sets the bit only once. Events 0..7 map to status bits 0..7, and events 8 and 9 map to status bits 16 and 17.
- R3: A control write with a 1 at a status bit position clears that latched event. A 0 at that position leaves the event unchanged.
- R4: If a clear and a rising edge for the same event fall in the same cycle, the bit ends up set.
- R5: A control write replaces the enable set. Events 0..6 are enabled by bits 8..14, and events 8 and 9 are enabled by bits 24 and 25. `irq` is high exactly when some latched event is also enabled.
- R6: The port event (event 7) has no enable bit and never raises `irq`.
- R7: Control bit 15 is the soft reset. After the write that sets it, `engine_reset` is high from the next cycle, and status is forced to zero from the cycle after that for as long as the bit stays set. Events are dropped during that time. A later write with bit 15 at zero releases it.
- R8: When `bus_valid` is high, `bus_write` is low and `bus_addr` equals the register address, `bus_rdata` returns status. Any other bus cycle returns zero on `bus_rdata`. Writes to other addresses change nothing, and reads change nothing.
- R9: Status word bits other than 0..7, 16 and 17 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Control word on writes |
| bus_rdata | output | 32 | Status word on reads, zero otherwise |
| ev_src | input | 10 | Event source levels, one per event |
| irq | output | 1 | Interrupt request |
| engine_reset | output | 1 | Drawing-engine soft reset |

## Verification
The hardest case to reach from the ports is a clear and a fresh edge on the same event in the same cycle. Hitting it requires the source to have been low in the cycle before, while a control write carrying that event's clear bit is presented on the bus in the exact cycle the source rises. A directed step sets up this collision for a threshold event. The random phase then drives source levels that change every cycle alongside frequent control writes, which makes collisions on all ten events common. The soft-reset interval is also covered in both phases, including events that arrive while reset is held.

// File: rtl/gfx_irq_pkg.sv
// Shared constants and bit-position helpers for the interrupt register.
// Assumes ten events in a fixed order; positions are decoded by software.
package gfx_irq_pkg;

    localparam int NUM_EV   = 10;
    localparam int DATA_W   = 32;
    localparam int SRST_BIT = 15;
    localparam int PORT_EV  = 7;

    typedef enum logic [3:0] {
        EV_VSYNC, EV_BUSY, EV_BFULL, EV_BEMPTY, EV_CFULL,
        EV_CEMPTY, EV_BURST, EV_PORT, EV_THR_HI, EV_THR_LO
    } ev_e;

    // Status / clear bit position of an event.
    function automatic int stat_bit(int ev);
        return (ev < 8) ? ev : ev + 8;
    endfunction

    // Whether an event owns an enable bit.
    function automatic bit has_enable(int ev);
        return ev != PORT_EV;
    endfunction

    // Enable bit position of an event (only valid when has_enable).
    function automatic int en_bit(int ev);
        return (ev < 7) ? ev + 8 : ev + 16;
    endfunction

    // Mask of all implemented status positions.
    function automatic logic [DATA_W-1:0] stat_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int e = 0; e < NUM_EV; e++) m[stat_bit(e)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gfx_irq_edge.sv
// Rising-edge detector for the event source levels.
// Assumes sources are synchronous to clk.
module gfx_irq_edge #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    // Remember last cycle's source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
    end

    assign rise_o = src_i & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R2

endmodule

// File: rtl/gfx_irq_ctrl.sv
// Control word decode: clear pulses, enable register, soft-reset register.
// Assumes wr_hit_i is already qualified by strobe, write and address.
module gfx_irq_ctrl
    import gfx_irq_pkg::*;
#(
    parameter int NE = NUM_EV,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit_i,
    input  logic [DW-1:0] wdata_i,
    output logic [NE-1:0] clr_o,
    output logic [NE-1:0] en_o,
    output logic          srst_o
);

    logic [NE-1:0] en_next;
    logic [NE-1:0] en_q;
    logic          srst_q;

    for (genvar e = 0; e < NE; e++) begin : g_ev
        assign clr_o[e] = wr_hit_i & wdata_i[stat_bit(e)];
        if (has_enable(e)) begin : g_en
            assign en_next[e] = wdata_i[en_bit(e)];
        end else begin : g_noen
            assign en_next[e] = 1'b0;
        end
    end

    // Load enables and soft reset on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            srst_q <= 1'b0;
        end else if (wr_hit_i) begin
            en_q   <= en_next;
            srst_q <= wdata_i[SRST_BIT];
        end
    end

    assign en_o   = en_q;
    assign srst_o = srst_q;

    AST_SRST_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_i |=> (srst_o == $past(wdata_i[SRST_BIT]))); // R7
    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit_i |=> $stable(srst_o)); // R7
    AST_PORT_NEVER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_i |=> !en_o[PORT_EV]); // R6

endmodule

// File: rtl/gfx_irq_status.sv
// Latched event status bank: set on edge, clear on request, flushed by soft reset.
// Assumes set has priority over clear in the same cycle.
module gfx_irq_status #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    input  logic         srst_i,
    output logic [N-1:0] st_o
);

    logic [N-1:0] st_q;

    // Update latched events each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (srst_i) st_q <= '0;
        else             st_q <= (st_q & ~clr_i) | rise_i;
    end

    assign st_o = st_q;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_i |=> ((st_q & $past(rise_i)) == $past(rise_i))); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~rise_i)) |=> ((st_q & $past(clr_i & ~rise_i)) == '0)); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~$past(st_q) & ~$past(rise_i)) == '0)); // R2
    AST_SRST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (st_q == '0)); // R7

endmodule

// File: rtl/gfx_irq_regs.sv
// Top: shared-address status/control register with a single interrupt output.
// Reads at REG_ADDR return status; writes there load the control word.
module gfx_irq_regs
    import gfx_irq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EV-1:0] ev_src,
    output logic              irq,
    output logic              engine_reset
);

    localparam logic [DATA_W-1:0] STAT_MASK = stat_mask();

    logic              hit, wr_hit, rd_hit;
    logic [NUM_EV-1:0] rise, clr, en, st;
    logic              srst;
    logic [DATA_W-1:0] stat_word;

    assign hit    = bus_valid && (bus_addr == REG_ADDR);
    assign wr_hit = hit && bus_write;
    assign rd_hit = hit && !bus_write;

    gfx_irq_edge #(.N(NUM_EV)) u_edge (
        .clk(clk), .rst_n(rst_n), .src_i(ev_src), .rise_o(rise)
    );

    gfx_irq_ctrl #(.NE(NUM_EV), .DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_hit), .wdata_i(bus_wdata),
        .clr_o(clr), .en_o(en), .srst_o(srst)
    );

    gfx_irq_status #(.N(NUM_EV)) u_status (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr),
        .srst_i(srst), .st_o(st)
    );

    // Scatter latched events into their status word positions.
    always_comb begin
        stat_word = '0;
        for (int e = 0; e < NUM_EV; e++) stat_word[stat_bit(e)] = st[e];
    end

    assign bus_rdata    = rd_hit ? stat_word : '0;
    assign irq          = |(st & en);
    assign engine_reset = srst;

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st != '0)); // R5
    AST_PORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == NUM_EV'(1 << PORT_EV)) |-> !irq); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~STAT_MASK) == '0)); // R9

endmodule

// File: tb/tb_gfx_irq_regs.sv
`timescale 1ns/1ps
module tb_gfx_irq_regs;

    localparam logic [7:0]  RA     = 8'h04;
    localparam logic [7:0]  OTHER  = 8'h10;
    localparam logic [31:0] ALL_EN = 32'h0300_7F00;

    logic        clk, rst_n;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [9:0]  ev_src;
    logic        irq, engine_reset;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [9:0] m_st, m_en, m_prev;
    logic       m_srst;

    gfx_irq_regs #(.ADDR_W(8), .REG_ADDR(RA)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_src(ev_src), .irq(irq), .engine_reset(engine_reset)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic int sp(int e);
        if (e < 8) return e;
        return 16 + (e - 8);
    endfunction

    function automatic int ep(int e);
        if (e < 7) return 8 + e;
        return 24 + (e - 8);
    endfunction

    function automatic logic [31:0] exp_rd(logic v, logic w, logic [7:0] a);
        logic [31:0] r;
        r = '0;
        if (v && !w && a == RA)
            for (int e = 0; e < 10; e++) r[sp(e)] = m_st[e];
        return r;
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        for (int e = 0; e < 10; e++)
            if (e != 7 && m_st[e] && m_en[e]) r = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic v, logic w, logic [7:0] a, logic [31:0] d,
                        logic [9:0] s, string tag);
        logic [9:0] nst;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; ev_src = s;
        #1;
        check(tag, "rdata", bus_rdata, exp_rd(v, w, a));
        check(tag, "irq", {31'd0, irq}, {31'd0, exp_irq()});
        check(tag, "engine_reset", {31'd0, engine_reset}, {31'd0, m_srst});
        @(posedge clk);
        for (int e = 0; e < 10; e++) begin
            if (m_srst)                                  nst[e] = 1'b0;
            else if (s[e] && !m_prev[e])                 nst[e] = 1'b1;
            else if (v && w && a == RA && d[sp(e)])      nst[e] = 1'b0;
            else                                         nst[e] = m_st[e];
        end
        m_st   = nst;
        m_prev = s;
        if (v && w && a == RA) begin
            for (int e = 0; e < 10; e++) m_en[e] = (e == 7) ? 1'b0 : d[ep(e)];
            m_srst = d[15];
        end
    endtask

    task automatic wr(logic [31:0] d, logic [9:0] s, string tag);
        step(1'b1, 1'b1, RA, d, s, tag);
    endtask

    task automatic rd(logic [9:0] s, string tag);
        step(1'b1, 1'b0, RA, 32'h0, s, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [9:0] s;
        seed = $urandom(32'h1A2B3C);
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_wdata = '0; ev_src = '0;
        m_st = '0; m_en = '0; m_prev = '0; m_srst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        rd(10'h000, "R1");
        wr(ALL_EN, 10'h000, "R5");
        rd(10'h001, "R2");
        rd(10'h000, "R5");
        wr(ALL_EN | 32'h1, 10'h000, "R3");
        rd(10'h000, "R3");
        rd(10'h102, "R2");
        rd(10'h000, "R2");
        wr(ALL_EN | 32'h0001_0000, 10'h000, "R3");
        rd(10'h000, "R3");
        wr(ALL_EN | 32'h0003_00FF, 10'h000, "R3");
        rd(10'h000, "R4");
        wr(ALL_EN | 32'h0002_0000, 10'h200, "R4");
        rd(10'h000, "R4");
        wr(ALL_EN | 32'h0003_00FF, 10'h000, "R3");
        rd(10'h008, "R2");
        rd(10'h008, "R2");
        wr(ALL_EN | 32'h8, 10'h008, "R2");
        rd(10'h008, "R2");
        rd(10'h000, "R2");
        rd(10'h080, "R6");
        rd(10'h000, "R6");
        wr(32'h0003_00FF, 10'h000, "R5");
        rd(10'h001, "R5");
        rd(10'h000, "R5");
        step(1'b1, 1'b1, OTHER, 32'hFFFF_FFFF, 10'h000, "R8");
        step(1'b1, 1'b0, OTHER, 32'h0, 10'h000, "R8");
        step(1'b0, 1'b0, RA, 32'h0, 10'h000, "R8");
        rd(10'h000, "R8");
        wr(ALL_EN, 10'h000, "R9");
        rd(10'h300, "R9");
        rd(10'h000, "R9");
        wr(ALL_EN | 32'h8000, 10'h000, "R7");
        rd(10'h000, "R7");
        rd(10'h021, "R7");
        rd(10'h000, "R7");
        wr(ALL_EN, 10'h000, "R7");
        rd(10'h004, "R7");
        rd(10'h000, "R7");

        for (int i = 0; i < 3000; i++) begin
            logic v, w;
            logic [7:0] a;
            logic [31:0] d;
            s = 10'($urandom);
            v = ($urandom % 4) != 0;
            w = ($urandom % 2) != 0;
            a = (($urandom % 8) == 0) ? OTHER : RA;
            d = $urandom;
            if (($urandom % 16) != 0) d[15] = 1'b0;
            step(v, w, a, d, s, "R2");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule